// File: doc/BRIEF.md
# Multichannel Thermal Shutdown and Alert Controller

This block watches four temperature channels: one on-die sensor (channel 0) and three remote sensors (channels 1 to 3). A strobe marks each new set of conversion results. The block compares every reading against a programmable over-temperature threshold for that channel. Any reading above its threshold sets a sticky status bit. A channel that software has linked into the shutdown path also trips a hysteresis latch, and that latch drives the shutdown output. A separate latch compares remote channel 1 against a fixed hardware limit. This latch always drives shutdown and releases with a fixed 10-degree band.

The alert pin is active low and is modelled as an open-drain driver. It pulls low while any unmasked channel has a sticky over-limit bit or a sensor fault. The alert mask has no effect on shutdown.

Each hysteresis latch is a two-state machine with states ST_COOL and ST_HOT. Transition TRIP goes from ST_COOL to ST_HOT: it fires on a conversion strobe when the latch is armed and the reading is above the limit. Transition COOL_DOWN goes from ST_HOT to ST_COOL: it fires on a strobe when the reading is below the release threshold. Transition DISARM goes from ST_HOT to ST_COOL on any cycle in which the latch is not armed. The hardware latch is always armed.

Top module: `thermal_guard`

## Requirements
- R1: After reset, shutdown is 0 and alert_n is 1. The link, mask and status registers read 0x00, and every channel threshold reads 0x55.
- R2: Register addresses are as follows. Addresses 0 to 3 hold the thresholds of channels 0 to 3. Address 4 is the link register: bit 0 is the on-die channel, bit 1 is remote 1, bit 2 is remote 2, and its other bits read 0. Address 5 is the mask register: bits 3:0 map to channels 0 to 3, and bits 7:4 read 0. Address 6 returns hw_limit_in, and writes to it are ignored. Address 7 returns the status bits in bits 3:0.
- R3: On a conversion strobe, a channel whose reading is strictly above its threshold sets its status bit, whether or not it is linked. A read of address 7 clears the status bits at the next clock edge. A conversion in that same cycle sets its bits again.
- R4: A linked channel asserts shutdown after a strobe on which its reading is above its threshold. It releases shutdown only after a strobe on which the reading is strictly below the threshold minus hyst_in.
- R5: A channel whose link bit is 0 never drives shutdown, even when its reading is over its threshold.
- R6: Remote channel 1 asserts shutdown after a strobe on which its reading is above hw_limit_in, whatever the link bits hold. It releases only after a strobe on which the reading is strictly below hw_limit_in minus 10.
- R7: When hyst_in exceeds the threshold, the release threshold saturates at 0.
- R8: alert_n is low exactly while some channel whose mask bit is 0 has its status bit or its fault_in bit set.
- R9: The mask register has no effect on shutdown.
- R10: Latches change only on cycles with conv_valid high. A reading that changes without the strobe leaves shutdown unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_valid | input | 1 | One-cycle strobe that marks new readings |
| temp_in | input | 32 | Readings; channel i occupies bits [8i+7:8i], unsigned degrees |
| fault_in | input | 4 | Sensor fault flag for each channel |
| hyst_in | input | 8 | Release band for the linked channels |
| hw_limit_in | input | 8 | Fixed hardware shutdown limit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (clears status when the address is 7) |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| shutdown | output | 1 | System shutdown request, active high |
| alert_n | output | 1 | Alert, active low |

## Verification
The assertions check the latch state machine on every cycle. A latch in ST_COOL without a qualifying strobe stays there, and a latch in ST_HOT with no release condition holds. A disarmed latch falls to ST_COOL. Every over-limit strobe on a linked channel, and every hardware-limit trip on remote 1, must raise shutdown on the next cycle, and every over-limit reading must set its status bit. Other behaviours need the bench's sequences to show them: the exact release points of both hysteresis bands, saturation of the release threshold, clear-on-read when a conversion lands in the same cycle, read-back of the unused register bits, and the mask's effect on the alert pin while shutdown is left unchanged.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
    typedef enum logic {
        ST_COOL = 1'b0,
        ST_HOT  = 1'b1
    } latch_state_e;

    localparam int AW = 3;
    localparam logic [AW-1:0] A_LINK  = 3'd4;
    localparam logic [AW-1:0] A_MASK  = 3'd5;
    localparam logic [AW-1:0] A_HWLIM = 3'd6;
    localparam logic [AW-1:0] A_STAT  = 3'd7;
endpackage

// File: rtl/thermal_latch.sv
module thermal_latch
    import thermal_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_valid,
    input  logic          arm,
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] limit,
    input  logic [TW-1:0] band,
    output logic          hot
);
    latch_state_e state_q, state_d;
    logic [TW-1:0] release_th;

    // Release point, floored at zero
    always_comb begin
        if (limit >= band) release_th = limit - band;
        else               release_th = '0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COOL: if (arm && conv_valid && (temp > limit)) state_d = ST_HOT;      // TRIP
            ST_HOT: begin
                if (!arm)                                      state_d = ST_COOL;    // DISARM
                else if (conv_valid && (temp < release_th))    state_d = ST_COOL;    // COOL_DOWN
            end
            default: state_d = ST_COOL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COOL;
        else        state_q <= state_d;
    end

    always_comb hot = (state_q == ST_HOT);

    AST_COOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COOL && !(conv_valid && arm && temp > limit)) |=> (state_q == ST_COOL)); // R10
    AST_HOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOT && arm && !(conv_valid && temp < release_th)) |=> (state_q == ST_HOT)); // R4
    AST_DISARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm) |=> (state_q == ST_COOL)); // R5
endmodule

// File: rtl/thermal_regs.sv
module thermal_regs
    import thermal_pkg::*;
#(
    parameter int           NCH       = 4,
    parameter int           TW        = 8,
    parameter int           LINKN     = 3,
    parameter logic [TW-1:0] LIMIT_RST = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic [NCH*TW-1:0] temp_flat,
    input  logic [TW-1:0]     hw_limit,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [TW-1:0]     wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [TW-1:0]     rd_data,
    output logic [LINKN*TW-1:0] limit_link,
    output logic [LINKN-1:0]  link,
    output logic [NCH-1:0]    mask,
    output logic [NCH-1:0]    status
);
    logic [TW-1:0]  limit_q [NCH];
    logic [LINKN-1:0] link_q;
    logic [NCH-1:0] mask_q;
    logic [NCH-1:0] status_q, status_d, over;
    logic           status_clr;

    for (genvar i = 0; i < NCH; i++) begin : g_lim
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  limit_q[i] <= LIMIT_RST;
            else if (wr_en && wr_addr == AW'(i))         limit_q[i] <= wr_data;
        end
        always_comb over[i] = temp_flat[i*TW +: TW] > limit_q[i];

        AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (conv_valid && temp_flat[i*TW +: TW] > limit_q[i]) |=> status_q[i]); // R3
    end

    for (genvar i = 0; i < LINKN; i++) begin : g_lout
        always_comb limit_link[i*TW +: TW] = limit_q[i];
    end

    always_comb status_clr = rd_en && (rd_addr == A_STAT);
    always_comb status_d = (status_clr ? '0 : status_q) | (conv_valid ? over : '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_q   <= '0;
            mask_q   <= '0;
            status_q <= '0;
        end else begin
            if (wr_en && wr_addr == A_LINK) link_q <= wr_data[LINKN-1:0];
            if (wr_en && wr_addr == A_MASK) mask_q <= wr_data[NCH-1:0];
            status_q <= status_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++)
            if (rd_addr == AW'(i)) rd_data = limit_q[i];
        if (rd_addr == A_LINK)  rd_data = TW'(link_q);
        if (rd_addr == A_MASK)  rd_data = TW'(mask_q);
        if (rd_addr == A_HWLIM) rd_data = hw_limit;
        if (rd_addr == A_STAT)  rd_data = TW'(status_q);
    end

    always_comb begin
        link   = link_q;
        mask   = mask_q;
        status = status_q;
    end
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
    import thermal_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int TW      = 8,
    parameter int LINKN   = 3,
    parameter int HW_CH   = 1,
    parameter int HW_BAND = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic [NCH*TW-1:0] temp_in,
    input  logic [NCH-1:0]    fault_in,
    input  logic [TW-1:0]     hyst_in,
    input  logic [TW-1:0]     hw_limit_in,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [TW-1:0]     wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [TW-1:0]     rd_data,
    output logic              shutdown,
    output logic              alert_n
);
    logic [LINKN*TW-1:0] limit_link;
    logic [LINKN-1:0]    link, link_hot;
    logic [NCH-1:0]      mask, status;
    logic                hw_hot;
    logic [TW-1:0]       hw_temp;

    thermal_regs #(.NCH(NCH), .TW(TW), .LINKN(LINKN)) u_regs (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .temp_flat(temp_in),
        .hw_limit(hw_limit_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .limit_link(limit_link), .link(link), .mask(mask), .status(status)
    );

    for (genvar i = 0; i < LINKN; i++) begin : g_ch
        thermal_latch #(.TW(TW)) u_latch (
            .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .arm(link[i]),
            .temp(temp_in[i*TW +: TW]), .limit(limit_link[i*TW +: TW]),
            .band(hyst_in), .hot(link_hot[i])
        );

        AST_LINK_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
            (conv_valid && link[i] && temp_in[i*TW +: TW] > limit_link[i*TW +: TW]) |=> shutdown); // R4
    end

    always_comb hw_temp = temp_in[HW_CH*TW +: TW];

    thermal_latch #(.TW(TW)) u_hw (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .arm(1'b1),
        .temp(hw_temp), .limit(hw_limit_in), .band(TW'(HW_BAND)), .hot(hw_hot)
    );

    always_comb begin
        shutdown = (|link_hot) | hw_hot;
        alert_n  = ~(|((status | fault_in) & ~mask));
    end

    AST_HW_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && hw_temp > hw_limit_in && $stable(hw_limit_in)) |=> shutdown); // R6
endmodule

// File: tb/sim_thermal_guard.sv
`timescale 1ns/1ps
module sim_thermal_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_valid = 1'b0;
    logic [31:0] temp_in = '0;
    logic [3:0]  fault_in = '0;
    logic [7:0]  hyst_in = 8'd10;
    logic [7:0]  hw_limit_in = 8'd120;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        shutdown, alert_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    thermal_guard u0 (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .temp_in(temp_in),
        .fault_in(fault_in), .hyst_in(hyst_in), .hw_limit_in(hw_limit_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .shutdown(shutdown), .alert_n(alert_n)
    );

    always #2 clk = ~clk;

    // {t3, t2, t1, t0, expected shutdown}; thresholds 80/90/70/60, link=ch0, hyst 10, hw 120
    localparam logic [32:0] VEC [13] = '{
        {8'd50, 8'd50, 8'd50,  8'd50, 1'b0},
        {8'd50, 8'd50, 8'd50,  8'd81, 1'b1},
        {8'd50, 8'd50, 8'd50,  8'd75, 1'b1},
        {8'd50, 8'd50, 8'd50,  8'd70, 1'b1},
        {8'd50, 8'd50, 8'd50,  8'd69, 1'b0},
        {8'd50, 8'd50, 8'd50,  8'd80, 1'b0},
        {8'd50, 8'd50, 8'd95,  8'd50, 1'b0},
        {8'd99, 8'd99, 8'd50,  8'd50, 1'b0},
        {8'd50, 8'd50, 8'd121, 8'd50, 1'b1},
        {8'd50, 8'd50, 8'd111, 8'd50, 1'b1},
        {8'd50, 8'd50, 8'd110, 8'd50, 1'b1},
        {8'd50, 8'd50, 8'd109, 8'd50, 1'b0},
        {8'd50, 8'd50, 8'd120, 8'd50, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic convert(input logic [31:0] t);
        @(negedge clk);
        temp_in = t; conv_valid = 1'b1;
        @(negedge clk);
        conv_valid = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 shutdown", shutdown, 0);
        chk("R1 alert_n", alert_n, 1);
        read_reg(3'd4, v); chk("R1 link", v, 8'h00);
        read_reg(3'd5, v); chk("R1 mask", v, 8'h00);
        read_reg(3'd7, v); chk("R1 status", v, 8'h00);
        read_reg(3'd0, v); chk("R1 limit0", v, 8'h55);

        write_reg(3'd0, 8'd80);
        write_reg(3'd1, 8'd90);
        write_reg(3'd2, 8'd70);
        write_reg(3'd3, 8'd60);
        write_reg(3'd4, 8'h01);

        // R4 R5 R6 vector walk
        for (int k = 0; k < 13; k++) begin
            convert(VEC[k][32:1]);
            chk($sformatf("R4/R5/R6 vec %0d shutdown", k), shutdown, VEC[k][0]);
        end

        // R3 clear on read
        read_reg(3'd7, v);
        convert({8'd50, 8'd50, 8'd50, 8'd50});
        read_reg(3'd7, v); chk("R3 cleared status", v, 8'h00);

        // R10 no strobe, no change
        @(negedge clk); temp_in[7:0] = 8'd90;
        repeat (2) @(negedge clk);
        chk("R10 shutdown without strobe", shutdown, 0);

        // R3 unlinked channel sets status; R5 no shutdown; R8 alert
        convert({8'd50, 8'd71, 8'd50, 8'd50});
        chk("R5 unlinked ch2 shutdown", shutdown, 0);
        chk("R8 alert from status", alert_n, 0);
        read_reg(3'd7, v); chk("R3 status ch2", v, 8'h04);
        chk("R8 alert after clear", alert_n, 1);
        read_reg(3'd7, v); chk("R3 status after read", v, 8'h00);

        // R8 fault and mask
        @(negedge clk); fault_in = 4'b1000;
        #1 chk("R8 fault alert", alert_n, 0);
        write_reg(3'd5, 8'h08);
        chk("R8 masked fault", alert_n, 1);
        write_reg(3'd5, 8'hFF);
        read_reg(3'd5, v); chk("R2 mask readback", v, 8'h0F);

        // R9 mask leaves shutdown alone
        convert({8'd50, 8'd50, 8'd50, 8'd85});
        chk("R9 shutdown with all masked", shutdown, 1);
        chk("R8 masked over-limit alert", alert_n, 1);
        convert({8'd50, 8'd50, 8'd50, 8'd50});
        chk("R4 release ch0", shutdown, 0);
        fault_in = 4'b0000;
        read_reg(3'd7, v); chk("R3 status ch0", v, 8'h01);

        // R3 conversion in the clearing cycle wins
        @(negedge clk);
        temp_in = {8'd50, 8'd50, 8'd50, 8'd85}; conv_valid = 1'b1;
        rd_en = 1'b1; rd_addr = 3'd7;
        @(negedge clk);
        conv_valid = 1'b0; rd_en = 1'b0;
        read_reg(3'd7, v); chk("R3 set beats clear", v, 8'h01);
        convert({8'd50, 8'd50, 8'd50, 8'd50});

        // R2 link width, hardware limit read-only
        write_reg(3'd4, 8'h0F);
        read_reg(3'd4, v); chk("R2 link readback", v, 8'h07);
        write_reg(3'd4, 8'h01);
        read_reg(3'd6, v); chk("R2 hw limit", v, 8'd120);
        write_reg(3'd6, 8'd0);
        read_reg(3'd6, v); chk("R2 hw limit write ignored", v, 8'd120);

        // R7 saturating release threshold
        write_reg(3'd0, 8'd5);
        convert({8'd50, 8'd50, 8'd50, 8'd6});
        chk("R7 trip low limit", shutdown, 1);
        convert({8'd50, 8'd50, 8'd50, 8'd0});
        chk("R7 saturated release holds", shutdown, 1);
        hyst_in = 8'd0;
        convert({8'd50, 8'd50, 8'd50, 8'd4});
        chk("R4 release with zero hysteresis", shutdown, 0);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule